// File: doc/BRIEF.md
# Snooze Entry and Recovery Controller

This block governs a retention sleep state for a synchronous memory. A single asynchronous request line, `zz_async`, asks for sleep when high and for wake-up when low. The block first resynchronises the request. It then requires the request to stay high for a standby interval before it declares the memory asleep. After wake-up it holds off address strobes for a recovery interval.

Both intervals are cycle counts. Each is derived from a clock-period parameter given in picoseconds and is the period-rounded-up equivalent of 100 ns. A request that drops before the standby interval has run out cancels the entry. In that case the block returns straight to normal operation, with no recovery wait.

While asleep, the block does three things:
- It closes the input gate, so the core ignores every control, address and data input. Only the request line is still watched.
- It forces the data bus to high impedance, whatever the output enable does.
- It reports that strobes are not accepted.

Stored data and the clock are not touched.

Top module: `lp_snooze_ctrl`

## Requirements
- R1: Synchronous active-high reset places the block in the awake state on the next edge: `sleep_o`=0, `in_gate_en_o`=1, `strobe_ok_o`=1, `out_hiz_o`=0. This also holds when reset arrives while asleep.
- R2: With the default parameters (8000 ps period, so the standby count N is ceil(100000/8000)=13), let the request go high before clock edge 1 and stay high. Then `sleep_o` first reads 1 after edge N+3. Those 3 extra edges are the two synchroniser flops and the state register.
- R3: A request that is high for N clock cycles or fewer never raises `sleep_o`. During such a pulse `strobe_ok_o` and `in_gate_en_o` stay 1 throughout, so there is no recovery wait. A request that is high for N+1 cycles does enter sleep.
- R4: Whenever `sleep_o` is 1, `in_gate_en_o` is 0, `out_hiz_o` is 1 and `strobe_ok_o` is 0.
- R5: Once asleep, the block stays asleep while the request is high. If the request is driven low after edge L, then `sleep_o` and `out_hiz_o` read 0 and `in_gate_en_o` reads 1 after edge L+3.
- R6: After wake-up, `strobe_ok_o` stays 0 for the recovery count M (13 by default, computed like N). It first reads 1 after edge L+3+M.
- R7: Raising the request again during recovery neither shortens recovery nor re-enters sleep early. Let A be the edge at which strobes return. Entry then starts on the next edge, and `sleep_o` first reads 1 after edge A+1+N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, kept running during sleep |
| rst | input | 1 | Synchronous active-high reset |
| zz_async | input | 1 | Asynchronous sleep request, high = sleep, low = wake |
| sleep_o | output | 1 | High while the retention state is in force |
| in_gate_en_o | output | 1 | High when the core may act on its other inputs |
| strobe_ok_o | output | 1 | High when address strobes may be accepted |
| out_hiz_o | output | 1 | High forces the data outputs to high impedance |

## Verification
Two of the block's functions can fall on the same clock edge: the end of recovery, and the start of a new standby interval for a request that was re-raised while recovering. The bench provokes this by lifting the request a few cycles into recovery and holding it high. It then judges the exact edge at which strobes return and the exact later edge at which sleep is re-entered, which proves that the re-raised request neither cut recovery short nor was lost. The abort boundary, a pulse of exactly N versus N+1 cycles, is judged the same way: the full trace of every output is read after each edge.

// File: rtl/lp_snooze_pkg.sv
package lp_snooze_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_ARMING = 2'd1,
    ST_ASLEEP = 2'd2,
    ST_WAKING = 2'd3
  } lp_state_e;

  // Ceiling division used to turn a time into clock cycles.
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/lp_zz_sync.sv
module lp_zz_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/lp_interval_timer.sv
module lp_interval_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (!(&cnt)) cnt <= cnt + W'(1);
  end

  // Done in the cycle that closes an interval of `limit` cycles.
  assign done = (cnt == limit - W'(1));
endmodule

// File: rtl/lp_snooze_fsm.sv
module lp_snooze_fsm
  import lp_snooze_pkg::*;
#(
  parameter int W         = 4,
  parameter int ENTRY_CYC = 13,
  parameter int RECOV_CYC = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         zz_s,
  input  logic         tmr_done,
  output logic         tmr_clr,
  output logic [W-1:0] tmr_limit,
  output logic         sleep_q,
  output logic         gate_q,
  output logic         strobe_q,
  output logic         hiz_q
);
  lp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_AWAKE:  if (zz_s) state_d = ST_ARMING;
      ST_ARMING: begin
        if (!zz_s)         state_d = ST_AWAKE;
        else if (tmr_done) state_d = ST_ASLEEP;
      end
      ST_ASLEEP: if (!zz_s)    state_d = ST_WAKING;
      ST_WAKING: if (tmr_done) state_d = ST_AWAKE;
      default:   state_d = ST_AWAKE;
    endcase
  end

  assign tmr_clr   = (state_d != state_q);
  assign tmr_limit = (state_q == ST_ARMING) ? W'(ENTRY_CYC) : W'(RECOV_CYC);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_AWAKE;
      sleep_q  <= 1'b0;
      gate_q   <= 1'b1;
      strobe_q <= 1'b1;
      hiz_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      sleep_q  <= (state_d == ST_ASLEEP);
      gate_q   <= (state_d != ST_ASLEEP);
      strobe_q <= (state_d == ST_AWAKE) || (state_d == ST_ARMING);
      hiz_q    <= (state_d == ST_ASLEEP);
    end
  end
endmodule

// File: rtl/lp_snooze_ctrl.sv
module lp_snooze_ctrl
  import lp_snooze_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 8000,
  parameter int STANDBY_PS    = 100000,
  parameter int RECOVER_PS    = 100000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic zz_async,
  output logic sleep_o,
  output logic in_gate_en_o,
  output logic strobe_ok_o,
  output logic out_hiz_o
);
  localparam int ENTRY_CYC = ceil_div(STANDBY_PS, CLK_PERIOD_PS);
  localparam int RECOV_CYC = ceil_div(RECOVER_PS, CLK_PERIOD_PS);
  localparam int MAX_CYC   = (ENTRY_CYC > RECOV_CYC) ? ENTRY_CYC : RECOV_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  logic             zz_s;
  logic             tmr_clr, tmr_done;
  logic [CNT_W-1:0] tmr_limit;

  lp_zz_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(zz_async), .q_sync(zz_s)
  );

  lp_interval_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .limit(tmr_limit), .done(tmr_done)
  );

  lp_snooze_fsm #(
    .W(CNT_W), .ENTRY_CYC(ENTRY_CYC), .RECOV_CYC(RECOV_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .zz_s(zz_s), .tmr_done(tmr_done),
    .tmr_clr(tmr_clr), .tmr_limit(tmr_limit),
    .sleep_q(sleep_o), .gate_q(in_gate_en_o),
    .strobe_q(strobe_ok_o), .hiz_q(out_hiz_o)
  );
endmodule

// File: rtl/lp_snooze_chk.sv
module lp_snooze_chk (
  input logic clk,
  input logic rst,
  input logic zz_async,
  input logic sleep_o,
  input logic in_gate_en_o,
  input logic strobe_ok_o,
  input logic out_hiz_o
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!sleep_o && in_gate_en_o && strobe_ok_o && !out_hiz_o));

  p_entry_needs_zz_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_o) |-> $past(zz_async, 3));

  p_sleep_isolates_r4: assert property (@(posedge clk) disable iff (rst)
    sleep_o |-> (!in_gate_en_o && out_hiz_o && !strobe_ok_o));

  p_wake_holds_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(sleep_o) && !$past(rst)) |-> !strobe_ok_o);

  p_no_quick_resleep_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_o) |=> !sleep_o);
endmodule

bind lp_snooze_ctrl lp_snooze_chk u_chk (.*);

// File: tb/test_lp_snooze_ctrl.sv
`timescale 1ns/1ps
module test_lp_snooze_ctrl;
  localparam int P  = 8000;
  localparam int N  = (100000 + P - 1) / P;
  localparam int M  = (100000 + P - 1) / P;
  localparam int NV = 5;
  localparam int  PULSE [NV] = '{1, 4, N, N + 1, N + 7};
  localparam bit  EXPSL [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  logic clk = 1'b0, rst = 1'b1, zz = 1'b0;
  logic sleep_o, gate_o, strobe_o, hiz_o;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  lp_snooze_ctrl #(.CLK_PERIOD_PS(P)) i_lp_snooze_ctrl (
    .clk(clk), .rst(rst), .zz_async(zz), .sleep_o(sleep_o),
    .in_gate_en_o(gate_o), .strobe_ok_o(strobe_o), .out_hiz_o(hiz_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_reset_outs(input string what);
    check(!sleep_o && gate_o && strobe_o && !hiz_o, "R1", what,
          {sleep_o, gate_o, strobe_o, hiz_o}, 4'b0110);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic run_pulse(input int len, input bit exp_sleep);
    int first_s = -1, fall_s = -1, rise_st = -1, iso_bad = 0;
    bit st_low = 0, gate_low = 0;
    zz = 1'b1;
    for (int c = 1; c <= len + M + 12; c++) begin
      @(posedge clk); @(negedge clk);
      if (c == len) zz = 1'b0;
      if (sleep_o && first_s < 0) first_s = c;
      if (!sleep_o && first_s >= 0 && fall_s < 0) fall_s = c;
      if (sleep_o && (gate_o || !hiz_o || strobe_o)) iso_bad++;
      if (!strobe_o) st_low = 1;
      if (strobe_o && st_low && rise_st < 0) rise_st = c;
      if (!gate_o) gate_low = 1;
    end
    if (exp_sleep) begin
      check(first_s == N + 3, "R2", "entry edge", first_s, N + 3);
      check(fall_s == len + 3, "R5", "exit edge", fall_s, len + 3);
      check(rise_st == len + 3 + M, "R6", "strobe return edge", rise_st, len + 3 + M);
      check(iso_bad == 0, "R4", "isolation while asleep", iso_bad, 0);
    end else begin
      check(first_s == -1, "R3", "aborted pulse slept", first_s, -1);
      check(!st_low && !gate_low, "R3", "abort disturbed gates",
            {st_low, gate_low}, 0);
    end
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    check_reset_outs("outputs under reset");
    rst = 1'b0;
    cycles(2);
    check_reset_outs("idle after reset");

    for (int v = 0; v < NV; v++) run_pulse(PULSE[v], EXPSL[v]);

    // Reset while asleep (R1)
    zz = 1'b1;
    cycles(N + 5);
    check(sleep_o == 1'b1, "R5", "asleep before reset", sleep_o, 1);
    rst = 1'b1;
    cycles(1);
    check_reset_outs("reset while asleep");
    rst = 1'b0;
    zz = 1'b0;
    cycles(M + 8);
    check_reset_outs("quiet after reset");

    // Re-raised request during recovery (R7)
    begin
      int a, first_s, early;
      zz = 1'b1;
      cycles(N + 6);
      check(sleep_o == 1'b1, "R5", "asleep before wake", sleep_o, 1);
      zz = 1'b0;
      a = 3 + M;
      first_s = -1; early = 0;
      for (int c = 1; c <= a + N + 3; c++) begin
        @(posedge clk); @(negedge clk);
        if (c == 5) zz = 1'b1;
        if (c == a - 1)
          check(strobe_o == 1'b0, "R7", "strobe still held", strobe_o, 0);
        if (c == a)
          check(strobe_o == 1'b1, "R7", "strobe returns on time", strobe_o, 1);
        if (sleep_o && c > 3 && first_s < 0) first_s = c;
        if (sleep_o && c > 3 && c < a + 1 + N) early++;
      end
      check(early == 0, "R7", "early re-entry", early, 0);
      check(first_s == a + 1 + N, "R7", "re-entry edge", first_s, a + 1 + N);
      zz = 1'b0;
      cycles(M + 8);
      check_reset_outs("settled after re-entry test");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule